// File: doc/BRIEF.md
# Floating-Point Compare and Select Unit

This unit takes two IEEE-754 single-precision operands and, in one registered stage, produces two things at once. The first is a three-bit condition code {flag_z, flag_p, flag_c} that ordinary integer branch logic can test. The second is a 32-bit result picked by an operation code. The selectable operations are ordered maximum and minimum, maximum and minimum by magnitude, and the sign-only operations: absolute value, negative absolute value and negate. A separate copy-sign control combines the sign of one operand with the exponent and fraction of the other.

The unit does no arithmetic and no rounding, and it raises no traps. A caller presents operands with `in_valid` high. Exactly one clock later, the result and the flags appear with `out_valid` high. Operations that only touch the sign move bit 31 alone, so NaN payloads pass through unchanged. Two zeros of either sign compare as equal.

The datapath has no state machine. The only sequencing is a single capture register: it loads when `in_valid` is high and holds its value otherwise.

Top module: `fp_cmpsel`

## Requirements
- R1: When A is greater than B, with neither a NaN, the flags {flag_z, flag_p, flag_c} are 3'b000.
- R2: When A is less than B, with neither a NaN, the flags are 3'b001 (only flag_c set).
- R3: When A equals B, the flags are 3'b100 (only flag_z set). +0 and -0 count as equal.
- R4: When either operand is a NaN (exponent all ones and fraction non-zero), the flags are 3'b111.
- R5: The flags reflect the comparison of A and B for every operation code. With op_sel 3'd0 (compare) and copy-sign off, the result is 32'h0.
- R6: op_sel 3'd1 (max) returns A when A > B and B otherwise. op_sel 3'd2 (min) returns A when A < B and B otherwise.
- R7: op_sel 3'd3 returns A when |A| > |B| and B otherwise. op_sel 3'd4 returns A when |A| < |B| and B otherwise. Magnitude means bits 30:0 taken as an unsigned number.
- R8: For op_sel 3'd1 to 3'd4, if exactly one operand is a NaN the other operand is returned. If both are NaNs the result is 32'h7FC00000.
- R9: op_sel 3'd5 returns A with bit 31 cleared. 3'd6 returns A with bit 31 set. 3'd7 returns A with bit 31 inverted. Bits 30:0 are always A's, including for NaNs.
- R10: When cpysgn_en is high it overrides op_sel. The result is {A[31] ^ cpysgn_neg, B[30:0]}.
- R11: out_valid equals in_valid delayed by exactly one clock. Result and flags load only on cycles where in_valid is high and hold otherwise.
- R12: A synchronous active-high reset clears out_valid, result and all three flags on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 3 | Operation code (see R5 to R9) |
| cpysgn_en | input | 1 | Copy-sign override |
| cpysgn_neg | input | 1 | Invert A's sign during copy-sign |
| opnd_a | input | 32 | Operand A, single precision |
| opnd_b | input | 32 | Operand B, single precision |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered selected value |
| flag_z | output | 1 | Equal or unordered |
| flag_p | output | 1 | Unordered |
| flag_c | output | 1 | Less than or unordered |

## Verification
Operands are drawn from a mix of signed zeros, infinities, quiet and signalling NaNs, random words, copies of the other operand, its negation and near neighbours. This mix separates equal from ordered cases, the sign-based branch of the compare from the magnitude branch, and one-NaN from two-NaN selection. Directed pairs cover +0 against -0, negative-against-negative ordering (where the magnitude order reverses), and a NaN payload passing through the sign operations. Idle cycles and a reset asserted during a valid input tell holding apart from capture and from clearing.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    typedef enum logic [2:0] {
        OP_CMP    = 3'd0,
        OP_MAX    = 3'd1,
        OP_MIN    = 3'd2,
        OP_MAXMAG = 3'd3,
        OP_MINMAG = 3'd4,
        OP_ABS    = 3'd5,
        OP_NABS   = 3'd6,
        OP_NEG    = 3'd7
    } fpcs_op_e;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic unord;
        logic nan_a;
        logic nan_b;
        logic mag_gt;
        logic mag_lt;
    } fpcs_rel_t;

    // canonical quiet NaN: sign 0, exponent all ones, top fraction bit set
    localparam logic [WORD_W-1:0] CANON_QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
endpackage

// File: rtl/fpcs_compare.sv
module fpcs_compare
    import fpcs_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] a,
    input  logic [EW+FW:0] b,
    output fpcs_rel_t      rel
);
    localparam int MSB = EW + FW;

    logic         sa, sb;
    logic [MSB-1:0] ma, mb;
    logic         both_zero;

    always_comb begin
        sa        = a[MSB];
        sb        = b[MSB];
        ma        = a[MSB-1:0];
        mb        = b[MSB-1:0];
        rel.nan_a = (&a[MSB-1:FW]) && (|a[FW-1:0]);
        rel.nan_b = (&b[MSB-1:FW]) && (|b[FW-1:0]);
        rel.unord = rel.nan_a || rel.nan_b;
        rel.mag_gt = ma > mb;
        rel.mag_lt = ma < mb;
        both_zero = (ma == '0) && (mb == '0);

        rel.lt = 1'b0;
        rel.eq = 1'b0;
        rel.gt = 1'b0;
        if (!rel.unord) begin
            if (both_zero || (a == b)) begin
                rel.eq = 1'b1;
            end else if (sa != sb) begin
                rel.gt = sb;
                rel.lt = sa;
            end else if (!sa) begin
                rel.gt = rel.mag_gt;
                rel.lt = rel.mag_lt;
            end else begin
                rel.gt = rel.mag_lt;
                rel.lt = rel.mag_gt;
            end
        end
    end
endmodule

// File: rtl/fpcs_select.sv
module fpcs_select
    import fpcs_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  fpcs_op_e       op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  fpcs_rel_t      rel,
    output logic [W-1:0]   res
);
    logic pick_a;

    always_comb begin
        unique case (op)
            OP_MAX:    pick_a = rel.gt;
            OP_MIN:    pick_a = rel.lt;
            OP_MAXMAG: pick_a = rel.mag_gt;
            OP_MINMAG: pick_a = rel.mag_lt;
            default:   pick_a = 1'b0;
        endcase

        if (rel.nan_a && rel.nan_b) begin
            res = CANON_QNAN;
        end else if (rel.nan_b) begin
            res = a;
        end else if (rel.nan_a) begin
            res = b;
        end else begin
            res = pick_a ? a : b;
        end
    end
endmodule

// File: rtl/fpcs_sign.sv
module fpcs_sign
    import fpcs_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  fpcs_op_e     op,
    input  logic         cs_en,
    input  logic         cs_neg,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    logic new_sign;

    always_comb begin
        if (cs_en) begin
            res = {a[W-1] ^ cs_neg, b[W-2:0]};
        end else begin
            unique case (op)
                OP_ABS:  new_sign = 1'b0;
                OP_NABS: new_sign = 1'b1;
                OP_NEG:  new_sign = ~a[W-1];
                default: new_sign = a[W-1];
            endcase
            res = {new_sign, a[W-2:0]};
        end
    end
endmodule

// File: rtl/fp_cmpsel.sv
module fp_cmpsel
    import fpcs_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic              cpysgn_en,
    input  logic              cpysgn_neg,
    input  logic [EW+FW:0]    opnd_a,
    input  logic [EW+FW:0]    opnd_b,
    output logic              out_valid,
    output logic [EW+FW:0]    result,
    output logic              flag_z,
    output logic              flag_p,
    output logic              flag_c
);
    localparam int W = EW + FW + 1;

    fpcs_op_e      op;
    fpcs_rel_t     rel;
    logic [W-1:0]  sel_res, sgn_res, nxt_res;
    logic [2:0]    nxt_flags;

    assign op = fpcs_op_e'(op_sel);

    fpcs_compare #(.EW(EW), .FW(FW)) u_cmp (
        .a   (opnd_a),
        .b   (opnd_b),
        .rel (rel)
    );

    fpcs_select #(.W(W)) u_sel (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .rel (rel),
        .res (sel_res)
    );

    fpcs_sign #(.W(W)) u_sgn (
        .op     (op),
        .cs_en  (cpysgn_en),
        .cs_neg (cpysgn_neg),
        .a      (opnd_a),
        .b      (opnd_b),
        .res    (sgn_res)
    );

    always_comb begin
        if (cpysgn_en) begin
            nxt_res = sgn_res;
        end else begin
            unique case (op)
                OP_CMP:                                 nxt_res = '0;
                OP_MAX, OP_MIN, OP_MAXMAG, OP_MINMAG:   nxt_res = sel_res;
                default:                                nxt_res = sgn_res;
            endcase
        end

        // condition code {z, p, c}
        if (rel.unord)      nxt_flags = 3'b111;
        else if (rel.eq)    nxt_flags = 3'b100;
        else if (rel.lt)    nxt_flags = 3'b001;
        else                nxt_flags = 3'b000;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_z    <= 1'b0;
            flag_p    <= 1'b0;
            flag_c    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result                   <= nxt_res;
                {flag_z, flag_p, flag_c} <= nxt_flags;
            end
        end
    end
endmodule

// File: rtl/fpcs_checker.sv
module fpcs_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [2:0]  op_sel,
    input logic        cpysgn_en,
    input logic        cpysgn_neg,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        flag_z,
    input logic        flag_p,
    input logic        flag_c
);
    logic a_nan, b_nan;
    assign a_nan = (opnd_a[30:23] == 8'hFF) && (opnd_a[22:0] != 23'd0);
    assign b_nan = (opnd_b[30:23] == 8'hFF) && (opnd_b[22:0] != 23'd0);

    a_r4_unordered_all_set: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (a_nan || b_nan)) |=> (flag_z && flag_p && flag_c));

    a_r4_parity_only_unordered: assert property (@(posedge clk) disable iff (rst)
        flag_p |-> (flag_z && flag_c));

    a_r9_abs_clears_sign: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cpysgn_en && op_sel == 3'd5) |=>
        (result == {1'b0, $past(opnd_a[30:0])}));

    a_r9_negate_flips_sign: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cpysgn_en && op_sel == 3'd7) |=>
        (result == {~$past(opnd_a[31]), $past(opnd_a[30:0])}));

    a_r10_copysign_body: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cpysgn_en) |=>
        (result == {$past(opnd_a[31]) ^ $past(cpysgn_neg), $past(opnd_b[30:0])}));

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_idle_clears_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(flag_z) && $stable(flag_c)));
endmodule

bind fp_cmpsel fpcs_checker u_fpcs_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .cpysgn_en  (cpysgn_en),
    .cpysgn_neg (cpysgn_neg),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .out_valid  (out_valid),
    .result     (result),
    .flag_z     (flag_z),
    .flag_p     (flag_p),
    .flag_c     (flag_c)
);

// File: tb/test_fp_cmpsel.sv
`timescale 1ns/1ps
module test_fp_cmpsel;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_sel;
    logic        cpysgn_en, cpysgn_neg;
    logic [31:0] opnd_a, opnd_b;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_z, flag_p, flag_c;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fp_cmpsel i_fp_cmpsel (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .cpysgn_en(cpysgn_en), .cpysgn_neg(cpysgn_neg),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .result(result), .flag_z(flag_z), .flag_p(flag_p), .flag_c(flag_c)
    );

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    // ordering key: signed magnitude mapped to a signed integer, both zeros -> 0
    function automatic longint key(input logic [31:0] x);
        longint m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    function automatic logic [2:0] ref_flags(input logic [31:0] a, b);
        if (is_nan(a) || is_nan(b)) return 3'b111;      // R4
        if (key(a) == key(b))       return 3'b100;      // R3
        if (key(a) <  key(b))       return 3'b001;      // R2
        return 3'b000;                                  // R1
    endfunction

    function automatic string flag_tag(input logic [31:0] a, b);
        if (is_nan(a) || is_nan(b)) return "R4";
        if (key(a) == key(b))       return "R3";
        if (key(a) <  key(b))       return "R2";
        return "R1";
    endfunction

    function automatic logic [31:0] ref_res(input logic [2:0] op, input bit cs, csn,
                                            input logic [31:0] a, b);
        bit pa;
        if (cs) return {a[31] ^ csn, b[30:0]};                    // R10
        case (op)
            3'd0: return 32'h0;                                   // R5
            3'd5: return {1'b0, a[30:0]};                         // R9
            3'd6: return {1'b1, a[30:0]};
            3'd7: return {~a[31], a[30:0]};
            default: begin
                if (is_nan(a) && is_nan(b)) return 32'h7FC00000;  // R8
                if (is_nan(a)) return b;
                if (is_nan(b)) return a;
                case (op)
                    3'd1: pa = key(a) > key(b);                   // R6
                    3'd2: pa = key(a) < key(b);
                    3'd3: pa = a[30:0] > b[30:0];                 // R7
                    default: pa = a[30:0] < b[30:0];
                endcase
                return pa ? a : b;
            end
        endcase
    endfunction

    function automatic string res_tag(input logic [2:0] op, input bit cs,
                                      input logic [31:0] a, b);
        if (cs) return "R10";
        if (op == 3'd0) return "R5";
        if (op >= 3'd5) return "R9";
        if (is_nan(a) || is_nan(b)) return "R8";
        if (op <= 3'd2) return "R6";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, one posedge captures, check at next negedge
    task automatic run_op(input logic [2:0] op, input bit cs, csn,
                          input logic [31:0] a, b);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; cpysgn_en = cs; cpysgn_neg = csn;
        opnd_a = a; opnd_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(res_tag(op, cs, a, b), result, ref_res(op, cs, csn, a, b));
        check(flag_tag(a, b), {29'd0, flag_z, flag_p, flag_c}, {29'd0, ref_flags(a, b)});
        check("R11", {31'd0, out_valid}, 32'd1);
    endtask

    function automatic logic [31:0] pick(input logic [31:0] other);
        logic s = 1'($urandom_range(0, 1));
        case ($urandom_range(0, 9))
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return {s, 8'hFF, 23'd0};
            3: return {s, 8'hFF, 1'b1, 22'($urandom)};
            4: return {s, 8'hFF, 1'b0, 22'($urandom) | 22'd1};
            5: return other;
            6: return {~other[31], other[30:0]};
            7: return other + 32'd1;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb, held;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; op_sel = 3'd0; cpysgn_en = 1'b0;
        cpysgn_neg = 1'b0; opnd_a = 32'h0; opnd_b = 32'h0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", {out_valid, flag_z, flag_p, flag_c, result[27:0]}, 32'h0);
        check("R12", result, 32'h0);
        rst = 1'b0;

        // directed corners
        run_op(3'd0, 0, 0, 32'h3F80_0000, 32'h3F00_0000);  // R1 1.0 > 0.5
        run_op(3'd0, 0, 0, 32'hBF80_0000, 32'hBF00_0000);  // R2 -1 < -0.5
        run_op(3'd0, 0, 0, 32'h0000_0000, 32'h8000_0000);  // R3 +0 == -0
        run_op(3'd0, 0, 0, 32'h7FC0_0001, 32'h3F80_0000);  // R4
        run_op(3'd1, 0, 0, 32'hC000_0000, 32'hBF80_0000);  // R6 max(-2,-1)
        run_op(3'd2, 0, 0, 32'hC000_0000, 32'hBF80_0000);  // R6 min
        run_op(3'd3, 0, 0, 32'hC000_0000, 32'h3F80_0000);  // R7 maxmag -> -2
        run_op(3'd4, 0, 0, 32'hC000_0000, 32'h3F80_0000);  // R7 minmag -> 1
        run_op(3'd1, 0, 0, 32'h7F80_0001, 32'h4000_0000);  // R8 one NaN
        run_op(3'd2, 0, 0, 32'hFFC0_0000, 32'h7F80_0005);  // R8 both NaN
        run_op(3'd5, 0, 0, 32'hFFC1_2345, 32'h0);          // R9 payload kept
        run_op(3'd6, 0, 0, 32'h4049_0FDB, 32'h0);          // R9
        run_op(3'd7, 0, 0, 32'h7F80_0003, 32'h0);          // R9
        run_op(3'd5, 1, 0, 32'h8000_0000, 32'h4049_0FDB);  // R10 override
        run_op(3'd7, 1, 1, 32'h8000_0000, 32'hC049_0FDB);  // R10 inverted

        // R11 hold on idle
        held = result;
        repeat (2) @(negedge clk);
        opnd_a = 32'h1234_5678; opnd_b = 32'h8765_4321; op_sel = 3'd1;
        @(negedge clk);
        check("R11", {31'd0, out_valid}, 32'd0);
        check("R11", result, held);

        // random mix
        for (int i = 0; i < 600; i++) begin
            ra = $urandom;
            ra = pick(ra);
            rb = pick(ra);
            if ($urandom_range(0, 1) != 0) begin
                logic [31:0] t = ra; ra = rb; rb = t;
            end
            run_op(3'($urandom_range(0, 7)), ($urandom_range(0, 7) == 0),
                   1'($urandom_range(0, 1)), ra, rb);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        // R12 reset wins over a valid input
        @(negedge clk);
        in_valid = 1'b1; op_sel = 3'd7; opnd_a = 32'h3F80_0000; opnd_b = 32'h7FC0_0000;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R12", {28'd0, out_valid, flag_z, flag_p, flag_c}, 32'h0);
        check("R12", result, 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule